// File: doc/BRIEF.md
# Serial Character Receiver with Per-Character Error Tags

This block recovers characters from an asynchronous serial line. A separate divider supplies a tick at sixteen times the bit rate. The receiver detects a start bit, checks it at mid-bit, and samples each following bit at its centre. It then emits one 12-bit word for each character: the data byte sits in the low byte and four error flags sit above it.

The character format is chosen at run time through static configuration inputs: the word length, the parity mode, and the number of stop bits. The parity mode can be none, odd, even, forced-one or forced-zero. The receiver captures the format when it detects a start edge, so a format change only takes effect on the next character. The word leaves as a one-cycle push strobe. If the downstream side is not ready when a character completes, that character is dropped and the next word delivered carries an overrun flag. A busy output shows when the receiver is in a frame or waiting after a break, and an enable input holds the engine idle.

Top module: `uart_rx_tag`

## Requirements
- R1: A delivered character appears as a one-cycle `word_valid_o` pulse. `word_o[7:0]` holds the data, bit 8 the framing error, bit 9 the parity error, bit 10 the break flag and bit 11 the overrun flag. After reset, `word_o` is zero and `word_valid_o` and `busy_o` are low.
- R2: `wlen_i` selects the data length: 0 = 5 bits, 1 = 6 bits, 2 = 7 bits, 3 = 8 bits. Bits are received least significant first, and data bits above the selected length read as zero.
- R3: A low line is accepted as a start bit only if it is still low at the sample taken 8 ticks after detection. Otherwise the receiver returns to idle and produces no word.
- R4: When `par_en_i` is 0, no parity bit is expected and bit 9 is never set.
- R5: When `par_en_i` is 1 and `par_stick_i` is 0, `par_even_i` = 0 selects odd parity and 1 selects even parity. A received parity bit that does not match sets bit 9.
- R6: When `par_en_i` is 1 and `par_stick_i` is 1, the parity bit must be 1 if `par_even_i` = 0 and must be 0 if `par_even_i` = 1. A mismatch sets bit 9.
- R7: `two_stop_i` = 1 expects two stop bits and 0 expects one. Bit 8 is set when any expected stop bit is sampled low.
- R8: When every data, parity and stop sample is low, the word has bit 10 and bit 8 set and data zero. The receiver then stays busy and ignores the line until it goes high.
- R9: If `word_ready_i` is low in the cycle a character completes, that character is discarded. The next delivered word has bit 11 set, and the word after that has it clear.
- R10: While `en_i` is low, the receiver is forced idle by the next clock edge, `busy_o` is low, and no word is produced.
- R11: The format inputs are captured when the start edge is detected. Changing them during a frame does not affect that character.
- R12: `busy_o` is high from start detection until the receiver is back in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receiver enable |
| tick_i | input | 1 | Oversampling tick, 16 per bit |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| wlen_i | input | 2 | Data length code |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | Even parity / forced-zero select |
| par_stick_i | input | 1 | Forced parity value mode |
| two_stop_i | input | 1 | Two stop bits |
| word_o | output | 12 | Received data and error flags |
| word_valid_o | output | 1 | One-cycle push strobe for word_o |
| word_ready_i | input | 1 | Downstream can accept a word |
| busy_o | output | 1 | Receiver in a frame or waiting after a break |

## Verification
On every cycle, the assertions check the following: the strobe lasts a single cycle, a break word also carries a framing error and zero data, no parity error appears when parity is disabled, bits above the captured length are zero, and a low enable forces idle. Only the bench scenarios can show the behaviours that depend on frame contents: the parity rules for all four parity modes, stop-bit counting, rejection of a short glitch, holding after a break until the line rises, the dropped character and the flag it leaves on the next word, and capture of the format at start detection. The bench reference model builds each expected word from the bits it drives onto the line.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 12;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
    logic       two_stop;
  } rx_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2,
    ST_HOLD
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  rx_cfg_t           cfg_i,
  output rx_cfg_t           cfg_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] sh_o,
  output logic              par_o,
  output logic              fe_o,
  output logic              brk_o,
  output logic              busy_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] MID_CNT = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(OSR - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic              par_q, fe_q, low_q, done_q;
  rx_cfg_t           cfg_q;

  logic       at_mid, at_end, line_low;
  logic [2:0] last_bit;

  assign at_mid   = (cnt_q == MID_CNT);
  assign at_end   = (cnt_q == END_CNT);
  assign line_low = ~rxd_i;
  assign last_bit = 3'd4 + {1'b0, cfg_q.wlen};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      fe_q    <= 1'b0;
      low_q   <= 1'b0;
      done_q  <= 1'b0;
      cfg_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else if (tick_i) begin
        unique case (state_q)
          ST_IDLE: if (line_low) begin
            state_q <= ST_START;
            cnt_q   <= '0;
            cfg_q   <= cfg_i;
          end
          ST_START: begin
            if (at_mid) begin
              cnt_q <= '0;
              if (line_low) begin
                state_q <= ST_DATA;
                bit_q   <= '0;
                sh_q    <= '0;
                low_q   <= 1'b1;
                fe_q    <= 1'b0;
                par_q   <= 1'b0;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (at_end) begin
              cnt_q <= '0;
              sh_q  <= {rxd_i, sh_q[BYTE_W-1:1]};
              low_q <= low_q & line_low;
              if (bit_q == last_bit) state_q <= cfg_q.par_en ? ST_PAR : ST_STOP1;
              else                   bit_q   <= bit_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (at_end) begin
              cnt_q   <= '0;
              par_q   <= rxd_i;
              low_q   <= low_q & line_low;
              state_q <= ST_STOP1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP1: begin
            if (at_end) begin
              cnt_q <= '0;
              fe_q  <= line_low;
              low_q <= low_q & line_low;
              if (cfg_q.two_stop) begin
                state_q <= ST_STOP2;
              end else begin
                done_q  <= 1'b1;
                state_q <= (low_q & line_low) ? ST_HOLD : ST_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP2: begin
            if (at_end) begin
              cnt_q   <= '0;
              fe_q    <= fe_q | line_low;
              low_q   <= low_q & line_low;
              done_q  <= 1'b1;
              state_q <= (low_q & line_low) ? ST_HOLD : ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_HOLD: if (!line_low) state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign done_o = done_q;
  assign sh_o   = sh_q;
  assign par_o  = par_q;
  assign fe_o   = fe_q;
  assign brk_o  = low_q;
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/rx_tag.sv
module rx_tag
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              ready_i,
  input  logic [1:0]        wlen_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              par_stick_i,
  input  logic [BYTE_W-1:0] sh_i,
  input  logic              par_i,
  input  logic              fe_i,
  input  logic              brk_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  logic [BYTE_W-1:0] data;
  logic              p_exp, pe;
  logic              ovr_q;

  // right-align the shifted bits for short words
  assign data  = sh_i >> (3'd3 - {1'b0, wlen_i});
  assign p_exp = par_stick_i ? ~par_even_i
                             : (par_even_i ? ^data : ~^data);
  assign pe    = par_en_i & (par_i ^ p_exp);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o  <= '0;
      valid_o <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (done_i) begin
        if (ready_i) begin
          word_o  <= {ovr_q, brk_i, pe, fe_i, data};
          valid_o <= 1'b1;
          ovr_q   <= 1'b0;
        end else begin
          ovr_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_tag.sv
module uart_rx_tag
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        tick_i,
  input  logic        rxd_i,
  input  logic [1:0]  wlen_i,
  input  logic        par_en_i,
  input  logic        par_even_i,
  input  logic        par_stick_i,
  input  logic        two_stop_i,
  output logic [11:0] word_o,
  output logic        word_valid_o,
  input  logic        word_ready_i,
  output logic        busy_o
);
  logic              rxd_s;
  rx_cfg_t           cfg_in, cfg_lat;
  logic              done;
  logic [BYTE_W-1:0] sh;
  logic              par_bit, fe, brk;

  assign cfg_in = '{wlen: wlen_i, par_en: par_en_i, par_even: par_even_i,
                    par_stick: par_stick_i, two_stop: two_stop_i};

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  rx_frame #(.OSR(OSR)) u_frame (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .tick_i(tick_i),
    .rxd_i (rxd_s),
    .cfg_i (cfg_in),
    .cfg_o (cfg_lat),
    .done_o(done),
    .sh_o  (sh),
    .par_o (par_bit),
    .fe_o  (fe),
    .brk_o (brk),
    .busy_o(busy_o)
  );

  rx_tag u_tag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done),
    .ready_i    (word_ready_i),
    .wlen_i     (cfg_lat.wlen),
    .par_en_i   (cfg_lat.par_en),
    .par_even_i (cfg_lat.par_even),
    .par_stick_i(cfg_lat.par_stick),
    .sh_i       (sh),
    .par_i      (par_bit),
    .fe_i       (fe),
    .brk_i      (brk),
    .word_o     (word_o),
    .valid_o    (word_valid_o)
  );
endmodule

// File: rtl/uart_rx_tag_chk.sv
module uart_rx_tag_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        busy_o,
  input logic        word_valid_o,
  input logic [11:0] word_o,
  input logic [1:0]  cfg_wlen,
  input logic        cfg_par_en
);
  // R1
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

  // R8
  brk_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && word_o[10]) |-> (word_o[8] && word_o[7:0] == 8'd0));

  // R4
  no_par_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && !cfg_par_en) |-> !word_o[9]);

  // R2
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> ((word_o[7:0] >> ({2'b00, cfg_wlen} + 4'd5)) == 8'd0));

  // R10
  en_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_o);
endmodule

bind uart_rx_tag uart_rx_tag_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .busy_o      (busy_o),
  .word_valid_o(word_valid_o),
  .word_o      (word_o),
  .cfg_wlen    (cfg_lat.wlen),
  .cfg_par_en  (cfg_lat.par_en)
);

// File: tb/sim_uart_rx_tag.sv
`timescale 1ns/1ps
module sim_uart_rx_tag;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic        tick = 1'b0;
  logic        rxd = 1'b1;
  logic [1:0]  wlen = 2'd3;
  logic        pen = 1'b0, peven = 1'b0, pstick = 1'b0, two = 1'b0;
  logic [11:0] word;
  logic        wvalid;
  logic        ready = 1'b1;
  logic        busy;

  int checks = 0, fails = 0, nvalid = 0;
  bit ovr_pend = 0, finished = 0;
  logic [11:0] exp_q[$];
  string       tag_q[$];

  uart_rx_tag u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick), .rxd_i(rxd),
    .wlen_i(wlen), .par_en_i(pen), .par_even_i(peven), .par_stick_i(pstick),
    .two_stop_i(two), .word_o(word), .word_valid_o(wvalid),
    .word_ready_i(ready), .busy_o(busy)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n) @(posedge tick);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference: expected word from line contents
  function automatic logic [11:0] model(input logic [7:0] d, input int nb,
      input bit p_en, input bit p_even, input bit p_stick, input logic pb,
      input logic s1, input logic s2, input bit two_s, input bit ovr);
    int mask;
    logic [7:0] dm;
    logic pexp, pe, fe, brk;
    mask = (1 << nb) - 1;
    dm   = d & mask[7:0];
    pexp = p_stick ? !p_even : (p_even ? ^dm : !(^dm));
    pe   = p_en && (pb != pexp);
    fe   = !s1 || (two_s && !s2);
    brk  = (dm == 8'd0) && (!p_en || !pb) && !s1 && (!two_s || !s2);
    return {ovr, brk, pe, fe, dm};
  endfunction

  function automatic logic good_par(input logic [7:0] d, input int nb,
                                    input bit p_even, input bit p_stick);
    int mask;
    logic [7:0] dm;
    mask = (1 << nb) - 1;
    dm   = d & mask[7:0];
    return p_stick ? !p_even : (p_even ? ^dm : !(^dm));
  endfunction

  task automatic send(input logic [7:0] d, input logic pb, input logic s1,
                      input logic s2, input string tag, input bit expect_word,
                      input bit mutate, input logic end_level);
    int nb = int'(wlen) + 5;
    bit c_pen = pen, c_two = two;
    if (expect_word) begin
      if (ready) begin
        exp_q.push_back(model(d, nb, pen, peven, pstick, pb, s1, s2, two, ovr_pend));
        tag_q.push_back(tag);
        ovr_pend = 0;
      end else begin
        ovr_pend = 1;
      end
    end
    rxd = 1'b0;
    wait_ticks(16);
    if (mutate) begin
      wlen = ~wlen;
      pen  = ~pen;
      two  = ~two;
    end
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      wait_ticks(16);
    end
    if (en) check(busy === 1'b1, "R12", "busy inside frame", busy, 1);
    if (c_pen) begin rxd = pb; wait_ticks(16); end
    rxd = s1;
    wait_ticks(16);
    if (c_two) begin rxd = s2; wait_ticks(16); end
    if (mutate) begin
      wlen = ~wlen;
      pen  = ~pen;
      two  = ~two;
    end
    rxd = end_level;
    wait_ticks(6);
  endtask

  task automatic send_ok(input logic [7:0] d, input string tag);
    send(d, good_par(d, int'(wlen) + 5, peven, pstick), 1'b1, 1'b1, tag, 1, 0, 1'b1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  // compare on every clock
  always @(negedge clk) begin
    if (rst_n && wvalid) begin
      logic [11:0] e;
      string t;
      nvalid++;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected word actual=%0h expected=none", word);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (word !== e) begin
          fails++;
          $display("FAIL %s word actual=%0h expected=%0h", t, word, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run hung actual=0 expected=1");
    finish_run();
  end

  initial begin
    int n0;
    repeat (4) @(negedge clk);
    check(wvalid === 1'b0 && busy === 1'b0 && word === 12'h0, "R1",
          "reset state", {word, wvalid, busy}, 0);
    rst_n = 1'b1;
    wait_ticks(20);

    // R1 R2: 8N1 and short lengths
    wlen = 2'd3; send_ok(8'hA5, "R1");
    send_ok(8'h3C, "R2");
    wlen = 2'd0; send_ok(8'hF5, "R2");
    wlen = 2'd1; send_ok(8'hEA, "R2");
    wlen = 2'd2; send_ok(8'hD9, "R2");

    // R5 normal parity
    wlen = 2'd3; pen = 1; pstick = 0;
    peven = 0; send_ok(8'h17, "R5");
    send(8'h17, !good_par(8'h17, 8, 0, 0), 1, 1, "R5", 1, 0, 1'b1);
    peven = 1; send_ok(8'h17, "R5");
    send(8'h80, !good_par(8'h80, 8, 1, 0), 1, 1, "R5", 1, 0, 1'b1);

    // R6 stick parity
    pstick = 1;
    peven = 0; send(8'h5A, 1'b1, 1, 1, "R6", 1, 0, 1'b1);
    send(8'h5A, 1'b0, 1, 1, "R6", 1, 0, 1'b1);
    peven = 1; send(8'h5B, 1'b0, 1, 1, "R6", 1, 0, 1'b1);
    send(8'h5B, 1'b1, 1, 1, "R6", 1, 0, 1'b1);
    pen = 0; pstick = 0; peven = 0;

    // R7 stop bits
    send(8'h42, 1'b0, 1'b0, 1'b1, "R7", 1, 0, 1'b1);
    two = 1;
    send_ok(8'h99, "R7");
    send(8'h99, 1'b0, 1'b1, 1'b0, "R7", 1, 0, 1'b1);
    two = 0;

    // R3 glitch shorter than half a bit
    n0 = nvalid;
    rxd = 1'b0; wait_ticks(3); rxd = 1'b1; wait_ticks(20);
    check(busy === 1'b0, "R3", "idle after glitch", busy, 0);
    check(nvalid == n0, "R3", "no word from glitch", nvalid - n0, 0);

    // R8 break then hold until the line rises
    n0 = nvalid;
    send(8'h00, 1'b0, 1'b0, 1'b0, "R8", 1, 0, 1'b0);
    wait_ticks(48);
    check(busy === 1'b1, "R8", "busy while line held low", busy, 1);
    check(nvalid == n0 + 1, "R8", "single word for break", nvalid - n0, 1);
    rxd = 1'b1; wait_ticks(4);
    check(busy === 1'b0, "R8", "idle after line rises", busy, 0);
    send_ok(8'h6E, "R8");

    // R9 overrun
    ready = 1'b0;
    send_ok(8'h33, "R9");
    ready = 1'b1;
    send_ok(8'h44, "R9");
    send_ok(8'h55, "R9");

    // R10 disabled receiver
    n0 = nvalid;
    en = 1'b0;
    @(negedge clk); @(negedge clk);
    check(busy === 1'b0, "R10", "busy low when disabled", busy, 0);
    send(8'h21, 1'b0, 1, 1, "R10", 0, 0, 1'b1);
    check(busy === 1'b0, "R10", "still idle", busy, 0);
    check(nvalid == n0, "R10", "no word when disabled", nvalid - n0, 0);
    en = 1'b1;
    wait_ticks(4);

    // R11 format captured at start
    wlen = 2'd1; pen = 0; two = 0;
    send(8'h2B, 1'b0, 1'b1, 1'b1, "R11", 1, 1, 1'b1);
    wlen = 2'd3;
    send_ok(8'hC3, "R11");

    wait_ticks(40);
    check(exp_q.size() == 0, "R1", "all expected words seen", exp_q.size(), 0);
    finish_run();
  end
endmodule